// File: doc/BRIEF.md
# Three-Weight Accumulator Pattern Generator

This block is a test-per-clock self-test stimulus source for a circuit with `WIDTH` inputs. An accumulator register adds a driving register into itself through a plain ripple-carry adder on every clock. The sum of those two registers is the pattern presented to the circuit under test. A fixed list of weight sessions decides, for every output bit, whether that bit is pseudorandom, held at 1, or held at 0. Inside each session, each held bit is forced in both registers, with opposite values in the two. Because a stage whose two operands differ hands its carry-in on unchanged, the random bits above a held bit still receive the carry chain. The adder itself is never altered.

A start pulse loads the seeds and the forcing of the first session. The block then steps through the sessions, spending a sampled number of clocks in each one. After the last pattern it raises done and freezes the output until the next start. The weight masks and seeds are parameters. `ONE_MASK` and `ZERO_MASK` each pack one `WIDTH`-bit slice per session, with session s at bits `[s*WIDTH +: WIDTH]`. When both masks mark the same bit, the 1 mask wins.

Top module: `tw_pattern_gen`

## Requirements
- R1: While rst_ni is low, pattern_o equals A_SEED and done_o is 0.
- R2: A start_i pulse seen while idle or done makes the next pattern (A_SEED with session 0's held bits cleared) OR its weight-1 bits, and the block enters session 0.
- R3: On every clock that presents a pattern of session s, each bit set in session s's 1 mask reads 1.
- R4: On every clock that presents a pattern of session s, each bit set only in session s's 0 mask reads 0.
- R5: Within a session, each new pattern's random bits equal the same bits of (previous pattern + B) mod 2^WIDTH. In B, the random bits hold B_SEED, the weight-1 bits are 0 and the weight-0 bits are 1.
- R6: Each session presents exactly L patterns. L is sess_len_i as sampled at the start pulse, with 0 treated as 1, and later changes to sess_len_i have no effect until the next start.
- R7: Sessions run in order 0 to NUM_SESS-1. The first pattern of session s+1 is the sum of the last pattern of session s and the B of session s, with session s+1's forcing applied. B is then rebuilt for session s+1.
- R8: One clock after the last pattern of the last session, done_o rises. pattern_o and done_o then stay unchanged while start_i is low.
- R9: start_i is ignored while a run is in progress.
- R10: A start_i pulse while done clears done_o on the next clock and starts a fresh run as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when idle or done |
| sess_len_i | input | LEN_W | Patterns per session, sampled at start (0 means 1) |
| pattern_o | output | WIDTH | Pattern to the circuit under test (accumulator state) |
| done_o | output | 1 | All sessions finished; output frozen |

## Verification
The bench targets a held bit lying below random bits. A design that let the forced stage produce its own carry, or forced only the accumulator and not the driving register, would corrupt the random bits above it while the held bits still looked right. It also goes after the session boundaries: a zero length, a length changed in the middle of a run, and an off-by-one counter would each give one pattern too many or too few in a session, or apply the new weights one clock late. Start pulses are sent during a run and after done, so a design that restarted in the middle of a run, or that did not keep its output frozen, would depart from the cycle-by-cycle reference model.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tw_state_e;
endpackage

// File: rtl/tw_sess_ctrl.sv
module tw_sess_ctrl import tw_pkg::*; #(
  parameter int NUM_SESS = 2,
  parameter int LEN_W    = 8,
  parameter int SESS_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  sess_len_i,
  output logic              upd_o,
  output logic              load_o,
  output logic [SESS_W-1:0] upd_sess_o,
  output logic [SESS_W-1:0] cur_sess_o,
  output logic              run_o,
  output logic              done_o
);
  localparam logic [SESS_W-1:0] LAST_SESS = SESS_W'(NUM_SESS - 1);

  tw_state_e         state_q, state_d;
  logic [SESS_W-1:0] sess_q, sess_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d, len_q, len_d;
  logic              running, last_cyc, last_sess, load, adv, step;

  assign running   = (state_q == ST_RUN);
  assign last_cyc  = (cnt_q == LEN_W'(len_q - LEN_W'(1)));
  assign last_sess = (sess_q == LAST_SESS);
  assign load      = start_i && !running;
  assign adv       = running && last_cyc && !last_sess;
  assign step      = running && !last_cyc;

  always_comb begin
    state_d = state_q;
    sess_d  = sess_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (load) begin
      state_d = ST_RUN;
      sess_d  = '0;
      cnt_d   = '0;
      len_d   = (sess_len_i == '0) ? LEN_W'(1) : sess_len_i;
    end else if (step) begin
      cnt_d = cnt_q + LEN_W'(1);
    end else if (adv) begin
      sess_d = sess_q + SESS_W'(1);
      cnt_d  = '0;
    end else if (running) begin
      state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sess_q  <= '0;
      cnt_q   <= '0;
      len_q   <= LEN_W'(1);
    end else begin
      state_q <= state_d;
      sess_q  <= sess_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  assign upd_o      = load || adv || step;
  assign load_o     = load;
  assign upd_sess_o = load ? '0 : (adv ? sess_q + SESS_W'(1) : sess_q);
  assign cur_sess_o = sess_q;
  assign run_o      = running;
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/tw_weight_dec.sv
module tw_weight_dec #(
  parameter int                         WIDTH     = 5,
  parameter int                         NUM_SESS  = 2,
  parameter int                         SESS_W    = 1,
  parameter logic [NUM_SESS*WIDTH-1:0]  ONE_MASK  = '0,
  parameter logic [NUM_SESS*WIDTH-1:0]  ZERO_MASK = '0
) (
  input  logic [SESS_W-1:0] sess_i,
  output logic [WIDTH-1:0]  set_o,
  output logic [WIDTH-1:0]  clr_o
);
  logic [WIDTH-1:0] one_tab  [NUM_SESS];
  logic [WIDTH-1:0] zero_tab [NUM_SESS];

  for (genvar s = 0; s < NUM_SESS; s++) begin : g_tab
    assign one_tab[s]  = ONE_MASK[s*WIDTH +: WIDTH];
    assign zero_tab[s] = ZERO_MASK[s*WIDTH +: WIDTH] & ~ONE_MASK[s*WIDTH +: WIDTH];
  end

  always_comb begin
    set_o = '0;
    clr_o = '0;
    for (int s = 0; s < NUM_SESS; s++) begin
      if (sess_i == SESS_W'(s)) begin
        set_o = one_tab[s];
        clr_o = zero_tab[s];
      end
    end
  end
endmodule

// File: rtl/tw_acc_cell.sv
module tw_acc_cell #(
  parameter logic A_INIT = 1'b0,
  parameter logic B_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic load_i,
  input  logic set_i,   // A set, B clear
  input  logic clr_i,   // A clear, B set
  input  logic cin_i,
  output logic cout_o,
  output logic a_o
);
  logic a_q, b_q, sum;

  // unmodified full adder
  assign sum    = a_q ^ b_q ^ cin_i;
  assign cout_o = (a_q & b_q) | (cin_i & (a_q ^ b_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= A_INIT;
      b_q <= B_INIT;
    end else if (upd_i) begin
      if (set_i) begin
        a_q <= 1'b1;
        b_q <= 1'b0;
      end else if (clr_i) begin
        a_q <= 1'b0;
        b_q <= 1'b1;
      end else begin
        a_q <= load_i ? A_INIT : sum;
        b_q <= B_INIT;
      end
    end
  end

  assign a_o = a_q;
endmodule

// File: rtl/tw_pattern_gen.sv
module tw_pattern_gen #(
  parameter int                         WIDTH     = 5,
  parameter int                         NUM_SESS  = 2,
  parameter int                         LEN_W     = 8,
  parameter logic [NUM_SESS*WIDTH-1:0]  ONE_MASK  = {5'b00010, 5'b00101},
  parameter logic [NUM_SESS*WIDTH-1:0]  ZERO_MASK = {5'b00101, 5'b00000},
  parameter logic [WIDTH-1:0]           A_SEED    = 5'b01001,
  parameter logic [WIDTH-1:0]           B_SEED    = 5'b10111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] sess_len_i,
  output logic [WIDTH-1:0] pattern_o,
  output logic             done_o
);
  localparam int SESS_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1;

  logic              upd_w, load_w, run_w;
  logic [SESS_W-1:0] upd_sess_w, cur_sess_w;
  logic [WIDTH-1:0]  set_w, clr_w;
  logic [WIDTH:0]    carry;

  tw_sess_ctrl #(
    .NUM_SESS(NUM_SESS), .LEN_W(LEN_W), .SESS_W(SESS_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sess_len_i(sess_len_i),
    .upd_o(upd_w), .load_o(load_w), .upd_sess_o(upd_sess_w),
    .cur_sess_o(cur_sess_w), .run_o(run_w), .done_o(done_o)
  );

  tw_weight_dec #(
    .WIDTH(WIDTH), .NUM_SESS(NUM_SESS), .SESS_W(SESS_W),
    .ONE_MASK(ONE_MASK), .ZERO_MASK(ZERO_MASK)
  ) u_dec (
    .sess_i(upd_sess_w), .set_o(set_w), .clr_o(clr_w)
  );

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    tw_acc_cell #(.A_INIT(A_SEED[i]), .B_INIT(B_SEED[i])) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_w), .load_i(load_w),
      .set_i(set_w[i]), .clr_i(clr_w[i]), .cin_i(carry[i]),
      .cout_o(carry[i+1]), .a_o(pattern_o[i])
    );
  end

  logic unused_w;
  assign unused_w = carry[WIDTH];
endmodule

// File: rtl/tw_pattern_gen_chk.sv
module tw_pattern_gen_chk #(
  parameter int                         WIDTH     = 5,
  parameter int                         NUM_SESS  = 2,
  parameter int                         SESS_W    = 1,
  parameter logic [NUM_SESS*WIDTH-1:0]  ONE_MASK  = '0,
  parameter logic [NUM_SESS*WIDTH-1:0]  ZERO_MASK = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic [WIDTH-1:0]  pattern_o,
  input logic              run_i,
  input logic [SESS_W-1:0] sess_i
);
  logic [WIDTH-1:0] one_m, zero_m;

  always_comb begin
    one_m  = '0;
    zero_m = '0;
    for (int s = 0; s < NUM_SESS; s++) begin
      if (sess_i == SESS_W'(s)) begin
        one_m  = ONE_MASK[s*WIDTH +: WIDTH];
        zero_m = ZERO_MASK[s*WIDTH +: WIDTH] & ~ONE_MASK[s*WIDTH +: WIDTH];
      end
    end
  end

  AST_HOLD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ((pattern_o & one_m) == one_m)); // R3
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ((pattern_o & zero_m) == '0)); // R4
  AST_DONE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(pattern_o))); // R8
  AST_RUN_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && done_o)); // R8
  AST_RUN_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && start_i) |=> (run_i || done_o)); // R9
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (run_i && !done_o)); // R10
endmodule

bind tw_pattern_gen tw_pattern_gen_chk #(
  .WIDTH(WIDTH), .NUM_SESS(NUM_SESS), .SESS_W(SESS_W),
  .ONE_MASK(ONE_MASK), .ZERO_MASK(ZERO_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .pattern_o(pattern_o), .run_i(run_w), .sess_i(cur_sess_w)
);

// File: tb/sim_tw_pattern_gen.sv
module sim_tw_pattern_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 5;
  localparam int NS = 3;
  localparam int LW = 8;
  localparam logic [NS*W-1:0] ONE  = {5'b00000, 5'b00010, 5'b00101};
  localparam logic [NS*W-1:0] ZERO = {5'b00000, 5'b00101, 5'b00000};
  localparam logic [W-1:0] AS = 5'b01001;
  localparam logic [W-1:0] BS = 5'b10111;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] len = '0;
  logic [W-1:0] pat;
  logic done;

  int checks = 0, errors = 0;
  string phase = "R1";

  // reference model state
  logic [W-1:0] m_a, m_b;
  int m_sess, m_cnt, m_len;
  bit m_run, m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_pattern_gen #(
    .WIDTH(W), .NUM_SESS(NS), .LEN_W(LW), .ONE_MASK(ONE), .ZERO_MASK(ZERO),
    .A_SEED(AS), .B_SEED(BS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sess_len_i(len),
    .pattern_o(pat), .done_o(done)
  );

  function automatic logic [W-1:0] hi(int s);
    return ONE[s*W +: W];
  endfunction
  function automatic logic [W-1:0] lo(int s);
    return ZERO[s*W +: W] & ~ONE[s*W +: W];
  endfunction

  task automatic enter(int s, logic [W-1:0] base);
    m_sess = s;
    m_cnt  = 0;
    m_a = (base & ~(hi(s) | lo(s))) | hi(s);
    m_b = (BS & ~(hi(s) | lo(s))) | lo(s);
  endtask

  task automatic model_reset();
    m_a = AS; m_b = BS; m_sess = 0; m_cnt = 0; m_len = 1; m_run = 0; m_done = 0;
  endtask

  task automatic model_step();
    logic [W-1:0] sum;
    sum = m_a + m_b;
    if (!m_run) begin
      if (start) begin
        m_len = (len == 0) ? 1 : int'(len);
        m_run = 1; m_done = 0;
        enter(0, AS);
      end
    end else if (m_cnt < m_len - 1) begin
      m_cnt++;
      m_a = (sum & ~(hi(m_sess) | lo(m_sess))) | hi(m_sess);
    end else if (m_sess < NS - 1) begin
      enter(m_sess + 1, sum);
    end else begin
      m_run = 0; m_done = 1;
    end
  endtask

  task automatic check(string tag, bit ok, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string tag;
    tag = phase;
    if (m_run && ((pat & hi(m_sess)) != hi(m_sess))) tag = "R3";
    else if (m_run && ((pat & lo(m_sess)) != '0)) tag = "R4";
    check(tag, pat === m_a, pat, m_a);
    check("R8", done === m_done, W'(done), W'(m_done));
  endtask

  // one clock: compare at negedge, then drive and advance model
  task automatic cyc(logic st, logic [LW-1:0] ln);
    @(negedge clk);
    compare();
    start = st;
    len = ln;
    if (rst_n) model_step();
  endtask

  task automatic run_count(logic [LW-1:0] ln, int exp_cnt, string tag);
    int n = 0;
    cyc(1'b1, ln);
    cyc(1'b0, ln);
    n = 1;
    while (!done && n < 1000) begin
      cyc(1'b0, ln);
      n++;
    end
    checks++;
    if (n != exp_cnt) begin
      errors++;
      $display("FAIL %s cycles-to-done actual=%0d expected=%0d", tag, n, exp_cnt);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL R8 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    phase = "R1";
    repeat (3) cyc(1'b0, 8'd0);
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    phase = "R5";
    repeat (2) cyc(1'b0, 8'd4);

    // R2: first pattern after start
    cyc(1'b1, 8'd4);
    @(negedge clk);
    check("R2", pat === ((AS & ~(hi(0) | lo(0))) | hi(0)), pat, (AS & ~(hi(0) | lo(0))) | hi(0));
    compare();
    start = 1'b0;
    model_step();

    // R5/R7 run with a length change mid-run (R6)
    phase = "R7";
    repeat (6) cyc(1'b0, 8'd4);
    phase = "R6";
    repeat (4) cyc(1'b0, 8'd2);
    // R9: start during run is ignored
    phase = "R9";
    cyc(1'b1, 8'd1);
    cyc(1'b0, 8'd1);
    phase = "R5";
    while (!m_done) cyc(1'b0, 8'd1);
    // R8: frozen while done
    phase = "R8";
    repeat (5) cyc(1'b0, 8'd9);

    // R10 restart from done, R6 zero length = one pattern per session
    phase = "R10";
    run_count(8'd0, NS * 1 + 1, "R6");
    phase = "R6";
    run_count(8'd5, NS * 5 + 1, "R6");
    phase = "R7";
    run_count(8'd11, NS * 11 + 1, "R7");
    // start held high across done restarts immediately
    phase = "R10";
    repeat (8) cyc(1'b1, 8'd2);
    phase = "R5";
    repeat (10) cyc(1'b0, 8'd2);
    cyc(1'b0, 8'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule